// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the status flags of a UART-style serial port and decides when each one is set and when it is cleared. The transmit and receive datapaths send it single-cycle event pulses:
- the transmit buffer was moved into the shifter;
- a frame, preamble or break finished sending;
- the receive shifter has a byte ready;
- the receive line went idle.

The CPU bus side sends it strobes for a status read, a data register read and a data register write. The block drives a registered 8-bit status byte, the received-data register and one combined interrupt request.

A flag is never cleared by a single bus access. The CPU must first read status while the flag is 1, which arms that flag. It must then make the matching data register access. A data write clears the transmit flags and a data read clears the receive flags. When a received byte arrives while the previous one is still unread, the new byte is dropped and the old one is kept. The idle flag fires only once for each idle period. Noise and framing error qualifiers arrive from outside with the receive event.

Top module: `sp_status_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `status` is 0xC0, `irq` is 0 and `rx_data` is 0.
- R2: The status byte fields are: bit 7 transmit-empty (TXE), bit 6 transmit-complete (TXC), bit 5 receive-full (RXF), bit 4 line-idle (LIDL), bit 3 overrun (OVR), bit 2 noise (NSE), bit 1 framing (FRM). Bit 0 is always 0.
- R3: A `ev_tx_load` pulse sets TXE at the next edge. A status read that sees TXE=1, followed later by a `bus_data_wr`, clears it.
- R4: A `ev_tx_end` pulse sets TXC in two cases. The first is `tx_en`=1 with TXE=1 and `tx_pending`=0. The second is `tx_en`=0. In every other case TXC does not change.
- R5: TXC is cleared by a status read that sees it set, followed by a `bus_data_wr`.
- R6: `ev_rx_ready` with RXF=0 loads `rx_byte` into `rx_data`, sets RXF, and sets NSE/FRM from `rx_noise`/`rx_frame_err`. A status read followed by `bus_data_rd` clears RXF, NSE and FRM.
- R7: `ev_rx_ready` with RXF=1 sets OVR and leaves `rx_data`, RXF, NSE and FRM unchanged. OVR clears through a status read followed by `bus_data_rd`.
- R8: `ev_line_idle` sets LIDL only while the idle gate is open. The gate is open after reset. Clearing LIDL through its handshake closes the gate. A `rx_line_active` pulse reopens it.
- R9: A data access clears only the flags that were 1 at an earlier status read. A flag set after that read survives the access.
- R10: A data access with no earlier arming status read clears nothing. A non-matching data access leaves the arming in place for the later matching access.
- R11: A set event in the same cycle as the clearing access wins, and the flag stays 1.
- R12: `irq` is registered. It equals the OR over bits 7..1 of the next status byte ANDed with `irq_en[i-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_load | input | 1 | Transmit buffer moved into shifter |
| ev_tx_end | input | 1 | Frame, preamble or break finished sending |
| tx_en | input | 1 | Transmitter enabled |
| tx_pending | input | 1 | More data, preamble or break queued |
| ev_rx_ready | input | 1 | Receive shifter holds a complete byte |
| rx_byte | input | DATA_W | Byte from the receive shifter |
| rx_noise | input | 1 | Noise seen on the byte |
| rx_frame_err | input | 1 | Framing error on the byte |
| ev_line_idle | input | 1 | Receiver detected an idle line |
| rx_line_active | input | 1 | Receive line showed activity |
| bus_stat_rd | input | 1 | CPU status register read strobe |
| bus_data_rd | input | 1 | CPU data register read strobe |
| bus_data_wr | input | 1 | CPU data register write strobe |
| irq_en | input | 7 | Per-flag interrupt enables for status bits 7..1 |
| status | output | 8 | Registered status byte |
| rx_data | output | DATA_W | Received data register |
| irq | output | 1 | Combined interrupt request |

## Verification
Assertions run on every cycle. They check that:
- a flag only falls after it was armed and given its matching access;
- an unarmed access leaves a set flag alone;
- a set event always leaves its flag high;
- overrun keeps `rx_data` stable;
- a reception into an empty register raises RXF;
- a disabled transmitter always raises TXC;
- the idle gate reopens only after line activity.

Some behaviour depends on the order of steps, which only the bench's scenarios can show. This covers the two-step clear crossing other bus cycles, the idle flag staying low until the line is active again, and an interrupt that follows both flag changes and enable changes.

// File: rtl/sp_stat_pkg.sv
package sp_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int NFLAG   = STAT_W - 1;
  localparam int B_TXE   = 7;
  localparam int B_TXC   = 6;
  localparam int B_RXF   = 5;
  localparam int B_LIDL  = 4;
  localparam int B_OVR   = 3;
  localparam int B_NSE   = 2;
  localparam int B_FRM   = 1;
  localparam logic [STAT_W-1:0] STAT_RST = 8'hC0;
endpackage

// File: rtl/sp_flag_cell.sv
module sp_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic stat_rd,
  input  logic data_acc,
  output logic flag_q,
  output logic flag_nxt,
  output logic clr_hit
);
  logic arm_q;

  assign clr_hit  = arm_q & data_acc;
  assign flag_nxt = set_ev | (flag_q & ~clr_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      if (data_acc)
        arm_q <= 1'b0;
      else if (stat_rd)
        arm_q <= arm_q | flag_q;
    end
  end

  AST_CLR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(arm_q && data_acc)); // R9
  AST_UNARMED_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !arm_q && flag_q) |=> flag_q); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> flag_q); // R11
endmodule

// File: rtl/sp_idle_gate.sv
module sp_idle_gate (
  input  logic clk,
  input  logic rst,
  input  logic line_active,
  input  logic idle_cleared,
  output logic gate_open
);
  always_ff @(posedge clk) begin
    if (rst)
      gate_open <= 1'b1;
    else if (line_active)
      gate_open <= 1'b1;
    else if (idle_cleared)
      gate_open <= 1'b0;
  end

  AST_REARM_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_open) |-> $past(line_active)); // R8
endmodule

// File: rtl/sp_rx_hold.sv
module sp_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)
      dout <= '0;
    else if (load)
      dout <= din;
  end
endmodule

// File: rtl/sp_status_ctrl.sv
module sp_status_ctrl
  import sp_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_tx_load,
  input  logic              ev_tx_end,
  input  logic              tx_en,
  input  logic              tx_pending,
  input  logic              ev_rx_ready,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_noise,
  input  logic              rx_frame_err,
  input  logic              ev_line_idle,
  input  logic              rx_line_active,
  input  logic              bus_stat_rd,
  input  logic              bus_data_rd,
  input  logic              bus_data_wr,
  input  logic [NFLAG-1:0]  irq_en,
  output logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] rx_data,
  output logic              irq
);
  logic [STAT_W-1:0] flag_q, flag_nxt, set_vec, acc_vec, clr_vec;
  logic rx_xfer, idle_ok;

  assign rx_xfer = ev_rx_ready & ~flag_q[B_RXF];

  always_comb begin
    set_vec         = '0;
    set_vec[B_TXE]  = ev_tx_load;
    set_vec[B_TXC]  = ev_tx_end & (~tx_en | (flag_q[B_TXE] & ~tx_pending));
    set_vec[B_RXF]  = rx_xfer;
    set_vec[B_LIDL] = ev_line_idle & idle_ok;
    set_vec[B_OVR]  = ev_rx_ready & flag_q[B_RXF];
    set_vec[B_NSE]  = rx_xfer & rx_noise;
    set_vec[B_FRM]  = rx_xfer & rx_frame_err;
  end

  assign flag_q[0]   = 1'b0;
  assign flag_nxt[0] = 1'b0;
  assign acc_vec[0]  = 1'b0;
  assign clr_vec[0]  = 1'b0;

  for (genvar i = 1; i < STAT_W; i++) begin : g_flag
    assign acc_vec[i] = (i >= B_TXC) ? bus_data_wr : bus_data_rd;
    sp_flag_cell #(.RST_VAL(STAT_RST[i])) u_cell (
      .clk      (clk),
      .rst      (rst),
      .set_ev   (set_vec[i]),
      .stat_rd  (bus_stat_rd),
      .data_acc (acc_vec[i]),
      .flag_q   (flag_q[i]),
      .flag_nxt (flag_nxt[i]),
      .clr_hit  (clr_vec[i])
    );
  end

  sp_idle_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .line_active  (rx_line_active),
    .idle_cleared (clr_vec[B_LIDL]),
    .gate_open    (idle_ok)
  );

  sp_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (rx_xfer),
    .din  (rx_byte),
    .dout (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else
      irq <= |(flag_nxt[STAT_W-1:1] & irq_en);
  end

  assign status = flag_q;

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_ready && status[B_RXF]) |=> $stable(rx_data)); // R7
  AST_RXF_LOADS: assert property (@(posedge clk) disable iff (rst)
    (ev_rx_ready && !status[B_RXF]) |=> status[B_RXF]); // R6
  AST_TXC_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (ev_tx_end && !tx_en) |=> status[B_TXC]); // R4
endmodule

// File: tb/sp_status_ctrl_bench.sv
module sp_status_ctrl_bench;
  logic clk = 0, rst = 1;
  logic ev_tx_load = 0, ev_tx_end = 0, tx_en = 0, tx_pending = 0;
  logic ev_rx_ready = 0, rx_noise = 0, rx_frame_err = 0;
  logic ev_line_idle = 0, rx_line_active = 0;
  logic bus_stat_rd = 0, bus_data_rd = 0, bus_data_wr = 0;
  logic [7:0] rx_byte = 0;
  logic [6:0] irq_en = 0;
  logic [7:0] status, rx_data;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sp_status_ctrl u_sp_status_ctrl (
    .clk(clk), .rst(rst), .ev_tx_load(ev_tx_load), .ev_tx_end(ev_tx_end),
    .tx_en(tx_en), .tx_pending(tx_pending), .ev_rx_ready(ev_rx_ready),
    .rx_byte(rx_byte), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
    .ev_line_idle(ev_line_idle), .rx_line_active(rx_line_active),
    .bus_stat_rd(bus_stat_rd), .bus_data_rd(bus_data_rd),
    .bus_data_wr(bus_data_wr), .irq_en(irq_en), .status(status),
    .rx_data(rx_data), .irq(irq)
  );

  // reference model built from the requirements
  logic [7:0] m_st, m_arm, m_data;
  logic m_irq, m_gate;
  logic [7:0] s_v, a_v, c_v, n_v, na_v;
  logic xf;
  always_comb begin
    xf = ev_rx_ready && !m_st[5];
    s_v = {ev_tx_load, ev_tx_end && (!tx_en || (m_st[7] && !tx_pending)),
           xf, ev_line_idle && m_gate, ev_rx_ready && m_st[5],
           xf && rx_noise, xf && rx_frame_err, 1'b0};
    a_v = {bus_data_wr, bus_data_wr, {5{bus_data_rd}}, 1'b0};
    c_v = m_arm & a_v;
    n_v = ((m_st & ~c_v) | s_v) & 8'hFE;
    for (int i = 0; i < 8; i++)
      na_v[i] = a_v[i] ? 1'b0 : (bus_stat_rd ? (m_arm[i] | m_st[i]) : m_arm[i]);
  end
  always @(posedge clk) begin
    if (rst) begin
      m_st <= 8'hC0; m_arm <= 0; m_data <= 0; m_irq <= 0; m_gate <= 1;
    end else begin
      m_st <= n_v; m_arm <= na_v & 8'hFE;
      if (xf) m_data <= rx_byte;
      m_irq <= |(n_v[7:1] & irq_en);
      if (rx_line_active) m_gate <= 1;
      else if (c_v[4]) m_gate <= 0;
    end
  end
  always @(negedge clk) if (!rst && !done) begin
    n_chk++;
    if (status !== m_st || irq !== m_irq || rx_data !== m_data) begin
      n_fail++;
      $display("FAIL R12/model: status=%h irq=%b data=%h expected %h %b %h",
               status, irq, rx_data, m_st, m_irq, m_data);
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    ev_tx_load = 0; ev_tx_end = 0; ev_rx_ready = 0; ev_line_idle = 0;
    rx_line_active = 0; bus_stat_rd = 0; bus_data_rd = 0; bus_data_wr = 0;
  endtask

  task automatic restore_tx();
    tx_en = 0; ev_tx_load = 1; ev_tx_end = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'hC0);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 data", rx_data, 8'h00);
    chk("R2 bit0", {7'd0, status[0]}, 8'h00);
  endtask

  task automatic t_tx();
    bus_stat_rd = 1; tick(); bus_data_wr = 1; tick();
    chk("R3 R5 clear", status, 8'h00);
    ev_tx_load = 1; tick();           chk("R3 set", status, 8'h80);
    tx_en = 1; ev_tx_end = 1; tick(); chk("R4 enabled idle", status, 8'hC0);
    bus_stat_rd = 1; tick(); bus_data_wr = 1; tick();
    ev_tx_end = 1; tick();            chk("R4 no set txe=0", status, 8'h00);
    ev_tx_load = 1; tick();
    tx_pending = 1; ev_tx_end = 1; tick(); chk("R4 pending", status, 8'h80);
    tx_pending = 0; tx_en = 0; ev_tx_end = 1; tick(); chk("R4 disabled", status, 8'hC0);
  endtask

  task automatic t_rx();
    rx_byte = 8'h5A; rx_noise = 1; ev_rx_ready = 1; tick();
    rx_noise = 0;
    chk("R6 set", status, 8'hE4); chk("R6 data", rx_data, 8'h5A);
    bus_stat_rd = 1; tick(); bus_data_rd = 1; tick();
    chk("R6 clear", status, 8'hC0);
  endtask

  task automatic t_overrun();
    rx_byte = 8'h11; ev_rx_ready = 1; tick();
    rx_byte = 8'h22; ev_rx_ready = 1; rx_frame_err = 1; tick(); rx_frame_err = 0;
    chk("R7 flag", status, 8'hE8); chk("R7 data kept", rx_data, 8'h11);
    bus_stat_rd = 1; tick(); bus_data_rd = 1; tick();
    chk("R7 clear", status, 8'hC0); chk("R7 data", rx_data, 8'h11);
  endtask

  task automatic t_idle();
    ev_line_idle = 1; tick(); chk("R8 set", status, 8'hD0);
    bus_stat_rd = 1; tick(); bus_data_rd = 1; tick(); chk("R8 clear", status, 8'hC0);
    ev_line_idle = 1; tick(); chk("R8 no reset w/o activity", status, 8'hC0);
    rx_line_active = 1; tick();
    ev_line_idle = 1; tick(); chk("R8 rearmed", status, 8'hD0);
    bus_stat_rd = 1; tick(); bus_data_rd = 1; tick(); chk("R8 clear2", status, 8'hC0);
  endtask

  task automatic t_armed_only();
    bus_stat_rd = 1; tick();
    rx_byte = 8'h33; ev_rx_ready = 1; tick();
    bus_data_rd = 1; tick(); chk("R10 unarmed read", status, 8'hE0);
    bus_data_wr = 1; tick(); chk("R9 armed only", status, 8'h20);
    bus_stat_rd = 1; tick(); bus_data_rd = 1; tick(); chk("R9 clear", status, 8'h00);
    restore_tx(); chk("R4 restore", status, 8'hC0);
  endtask

  task automatic t_intervening();
    rx_byte = 8'h44; ev_rx_ready = 1; tick();
    bus_stat_rd = 1; tick(); bus_data_wr = 1; tick();
    chk("R10 wr between", status, 8'h20);
    bus_data_rd = 1; tick(); chk("R10 arm kept", status, 8'h00);
    restore_tx();
  endtask

  task automatic t_set_wins();
    rx_byte = 8'h55; ev_rx_ready = 1; tick();
    bus_stat_rd = 1; tick();
    bus_data_wr = 1; ev_tx_load = 1; tick(); chk("R11 set wins", status, 8'hA0);
    bus_stat_rd = 1; tick(); bus_data_rd = 1; tick(); chk("R11 after", status, 8'h80);
    tx_en = 0; ev_tx_end = 1; tick(); chk("R11 restore", status, 8'hC0);
  endtask

  task automatic t_irq();
    irq_en = 7'b0010000; tick(); chk("R12 off", {7'd0, irq}, 8'h00);
    rx_byte = 8'h66; ev_rx_ready = 1; tick(); chk("R12 rxf", {7'd0, irq}, 8'h01);
    irq_en = 0; tick(); chk("R12 masked", {7'd0, irq}, 8'h00);
    irq_en = 7'b1000000; tick(); chk("R12 txe", {7'd0, irq}, 8'h01);
    irq_en = 0; bus_stat_rd = 1; tick(); bus_data_rd = 1; tick();
    chk("R12 end", status, 8'hC0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset(); t_tx(); t_rx(); t_overrun(); t_idle();
    t_armed_only(); t_intervening(); t_set_wins(); t_irq();
    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule